// File: doc/BRIEF.md
# Three-State Phase Comparator with Lock Monitor

This block sits between a frequency synthesizer's feedback divider and its charge pump. It watches two pulse trains, the reference and the divided local-oscillator signal, and turns their relative timing into two pump enables. `pump_hi` asks the pump to source current. It is raised while the divided edge has arrived and the matching reference edge has not, which is the case when the divided frequency runs above the reference. `pump_lo` asks the pump to sink current and is raised in the opposite case. When neither enable is active the pump output floats, which is the resting state of a locked loop.

Both pulse inputs are sampled by the fast block clock and only their rising edges count. A 2-bit dead-zone code suppresses the first few cycles of each phase-error interval, so very small errors cause no pump action. A lock monitor raises `unlock` for a reference period in which any error interval ran longer than a parameterised threshold. A deadlock guard forcibly closes an error interval that stays open across several reference periods, for example when the divider has stopped.

Top module: `tri_phase_cmp`

## Requirements
- R1: While `rst_n` is low, and for as long as no input edge has arrived after reset, `pump_hi`, `pump_lo` and `unlock` are all 0.
- R2: From the idle state, the first clock edge that samples `div_in` high (after a low sample) opens an up interval. With dead-zone code 0, `pump_hi` is 1 directly after that edge.
- R3: From the idle state, the first clock edge that samples `ref_in` high opens a down interval. With dead-zone code 0, `pump_lo` is 1 directly after that edge.
- R4: An open interval closes at the clock edge that samples the rising edge of the other input, and both enables are 0 after that edge. Rising edges sampled at the same clock edge open no interval. An interval opened G edges ahead of the other input's edge therefore lasts G cycles.
- R5: `pump_hi` and `pump_lo` are never 1 together. Both at 0 means a floating pump.
- R6: `dz_code` is read as an unsigned value D from 0 to 3. The enable is withheld for the first D cycles of every interval, so an interval of G cycles gives max(G-D, 0) enable cycles.
- R7: `unlock` changes only at clock edges that sample a rising edge of `ref_in`. At such an edge it becomes 1 if some interval in the period ending there, including the current cycle, had lasted more than ERR_THR cycles (default 6), and 0 otherwise.
- R8: While an interval is open, rising edges of `ref_in` that do not close it are counted. At the (DLK_PERIODS+1)-th such edge (default the third), the interval is forced closed and both enables are 0 after that edge.
- R9: A pulse input that stays high produces a single rising edge. After its interval has closed, it opens no new interval until it has gone low and high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ref_in | input | 1 | Reference pulse train |
| div_in | input | 1 | Divided local-oscillator pulse train |
| dz_code | input | 2 | Dead-zone code, 0 to 3 cycles |
| pump_hi | output | 1 | Pump source enable (divided signal ahead) |
| pump_lo | output | 1 | Pump sink enable (reference ahead) |
| unlock | output | 1 | Phase error exceeded the threshold in the last reference period |

## Verification
An input rising edge that is driven before clock edge k is sampled at k. The interval state, and with it `pump_hi` or `pump_lo` for dead-zone code 0, is updated at that same edge k. With code D the enable follows D edges later, and `unlock` and the deadlock clear take effect at the edge that samples the deciding reference edge. The bench drives inputs on falling edges and updates a behavioural model at each rising edge. It then compares all three outputs with the model 3 ns after the edge, once they have settled. The directed cases also count enable cycles over a whole stimulus and compare the count with the G-D and threshold arithmetic of the requirements.

// File: rtl/tpc_pkg.sv
`timescale 1ns/1ps
package tpc_pkg;
  localparam int unsigned DZ_W = 2;

  typedef struct packed {
    logic div_set;
    logic ref_set;
  } tpc_flops_t;

  function automatic int unsigned tpc_age_width(input int unsigned thr);
    int unsigned w;
    w = $clog2(thr + 1);
    return (w > DZ_W) ? w : DZ_W + 1;
  endfunction
endpackage

// File: rtl/tpc_edge_rise.sv
`timescale 1ns/1ps
module tpc_edge_rise #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic prev_q;
    logic prev_d;

    always_comb begin
      prev_d  = lvl[g];
      rise[g] = lvl[g] & ~prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/tpc_phase_core.sv
`timescale 1ns/1ps
module tpc_phase_core import tpc_pkg::*; #(
  parameter int unsigned DLK_PERIODS = 2,
  localparam int unsigned DLK_W = $clog2(DLK_PERIODS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_rise,
  input  logic             ref_rise,
  output tpc_flops_t       flops_q,
  output logic [DLK_W-1:0] dl_cnt_q
);
  tpc_flops_t       flops_d;
  logic [DLK_W-1:0] dl_cnt_d;
  logic             held;
  logic             held_next;
  logic             force_clr;
  logic             d_set;
  logic             r_set;
  logic             dl_en;

  always_comb begin
    held      = flops_q.div_set | flops_q.ref_set;
    force_clr = held & ref_rise & (dl_cnt_q == DLK_W'(DLK_PERIODS));
    d_set     = flops_q.div_set | div_rise;
    r_set     = flops_q.ref_set | ref_rise;
    if (force_clr || (d_set && r_set)) begin
      flops_d = '0;
    end else begin
      flops_d.div_set = d_set;
      flops_d.ref_set = r_set;
    end
    held_next = flops_d.div_set | flops_d.ref_set;
    dl_en     = 1'b1;
    if (!held_next) begin
      dl_cnt_d = '0;
    end else if (held && ref_rise) begin
      dl_cnt_d = dl_cnt_q + 1'b1;
    end else begin
      dl_cnt_d = dl_cnt_q;
      dl_en    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flops_q <= '0;
    else        flops_q <= flops_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dl_cnt_q <= '0;
    else if (dl_en) dl_cnt_q <= dl_cnt_d;
  end
endmodule

// File: rtl/tpc_pump_gate.sv
`timescale 1ns/1ps
module tpc_pump_gate import tpc_pkg::*; #(
  parameter int unsigned ERR_THR = 6,
  localparam int unsigned AGE_W = tpc_age_width(ERR_THR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tpc_flops_t       flops_q,
  input  logic [DZ_W-1:0]  dz,
  output logic [AGE_W-1:0] age_q,
  output logic             pump_hi,
  output logic             pump_lo
);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(ERR_THR);

  logic [AGE_W-1:0] age_d;
  logic             held;
  logic             past_dz;

  always_comb begin
    held = flops_q.div_set | flops_q.ref_set;
    if (!held)                age_d = '0;
    else if (age_q < AGE_MAX) age_d = age_q + 1'b1;
    else                      age_d = age_q;
    past_dz = (age_q >= AGE_W'(dz));
    pump_hi = flops_q.div_set & past_dz;
    pump_lo = flops_q.ref_set & past_dz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= '0;
    else        age_q <= age_d;
  end
endmodule

// File: rtl/tpc_lock_mon.sv
`timescale 1ns/1ps
module tpc_lock_mon #(
  parameter int unsigned ERR_THR = 6,
  parameter int unsigned AGE_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             held,
  input  logic [AGE_W-1:0] age_q,
  input  logic             ref_rise,
  output logic             unlock_q
);
  logic viol_q;
  logic viol_d;
  logic viol_now;
  logic unlock_d;

  always_comb begin
    viol_now = held & (age_q >= AGE_W'(ERR_THR));
    unlock_d = viol_q | viol_now;
    viol_d   = ref_rise ? 1'b0 : (viol_q | viol_now);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= 1'b0;
    else        viol_q <= viol_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        unlock_q <= 1'b0;
    else if (ref_rise) unlock_q <= unlock_d;
  end
endmodule

// File: rtl/tri_phase_cmp.sv
`timescale 1ns/1ps
module tri_phase_cmp import tpc_pkg::*; #(
  parameter int unsigned ERR_THR     = 6,
  parameter int unsigned DLK_PERIODS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_in,
  input  logic            div_in,
  input  logic [DZ_W-1:0] dz_code,
  output logic            pump_hi,
  output logic            pump_lo,
  output logic            unlock
);
  localparam int unsigned AGE_W = tpc_age_width(ERR_THR);
  localparam int unsigned DLK_W = $clog2(DLK_PERIODS + 1);

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic [1:0]       rise;
  logic             div_rise;
  logic             ref_rise;
  tpc_flops_t       flops_q;
  logic [DLK_W-1:0] dl_cnt_q;
  logic [AGE_W-1:0] age_q;
  logic             held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  tpc_edge_rise #(.N(2)) u_edge (
    .clk   (clk),
    .rst_n (core_rst_n),
    .lvl   ({ref_in, div_in}),
    .rise  (rise)
  );
  assign div_rise = rise[0];
  assign ref_rise = rise[1];

  tpc_phase_core #(.DLK_PERIODS(DLK_PERIODS)) u_core (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .div_rise (div_rise),
    .ref_rise (ref_rise),
    .flops_q  (flops_q),
    .dl_cnt_q (dl_cnt_q)
  );

  tpc_pump_gate #(.ERR_THR(ERR_THR)) u_gate (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .flops_q (flops_q),
    .dz      (dz_code),
    .age_q   (age_q),
    .pump_hi (pump_hi),
    .pump_lo (pump_lo)
  );

  assign held = flops_q.div_set | flops_q.ref_set;

  tpc_lock_mon #(.ERR_THR(ERR_THR), .AGE_W(AGE_W)) u_lock (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .held     (held),
    .age_q    (age_q),
    .ref_rise (ref_rise),
    .unlock_q (unlock)
  );
endmodule

// File: rtl/tri_phase_cmp_chk.sv
`timescale 1ns/1ps
module tri_phase_cmp_chk #(
  parameter int unsigned DLK_PERIODS = 2,
  parameter int unsigned DLK_W       = 2
) (
  input logic             clk,
  input logic             core_rst_n,
  input logic             div_rise,
  input logic             ref_rise,
  input logic             div_q,
  input logic             ref_q,
  input logic [1:0]       dz,
  input logic [DLK_W-1:0] dl_cnt,
  input logic             pump_hi,
  input logic             pump_lo,
  input logic             unlock
);
  AST_PUMP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!core_rst_n)
    !(pump_hi && pump_lo)); // R5
  AST_UP_FROM_DIV_EDGE: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(div_q) |-> $past(div_rise)); // R2
  AST_DN_FROM_REF_EDGE: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(ref_q) |-> $past(ref_rise)); // R3
  AST_LAG_EDGE_CLOSES: assert property (@(posedge clk) disable iff (!core_rst_n)
    ((div_q && ref_rise) || (ref_q && div_rise)) |=> (!pump_hi && !pump_lo)); // R4
  AST_DZ_NEEDS_HISTORY: assert property (@(posedge clk) disable iff (!core_rst_n)
    ((pump_hi || pump_lo) && (dz != 2'd0)) |-> ($past(div_q) || $past(ref_q))); // R6
  AST_UNLOCK_AT_REF_ONLY: assert property (@(posedge clk) disable iff (!core_rst_n)
    !ref_rise |=> $stable(unlock)); // R7
  AST_DLK_COUNT_BOUND: assert property (@(posedge clk) disable iff (!core_rst_n)
    dl_cnt <= DLK_W'(DLK_PERIODS)); // R8
endmodule

bind tri_phase_cmp tri_phase_cmp_chk #(
  .DLK_PERIODS (DLK_PERIODS),
  .DLK_W       (DLK_W)
) chk_i (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .div_rise   (div_rise),
  .ref_rise   (ref_rise),
  .div_q      (flops_q.div_set),
  .ref_q      (flops_q.ref_set),
  .dz         (dz_code),
  .dl_cnt     (dl_cnt_q),
  .pump_hi    (pump_hi),
  .pump_lo    (pump_lo),
  .unlock     (unlock)
);

// File: tb/tri_phase_cmp_tb_top.sv
`timescale 1ns/1ps
module tri_phase_cmp_tb_top;
  localparam int THR = 6;
  localparam int DLK = 2;

  logic       clk;
  logic       rst_n;
  logic       ref_in;
  logic       div_in;
  logic [1:0] dz;
  logic       pump_hi;
  logic       pump_lo;
  logic       unlock;

  int    n_chk;
  int    n_fail;
  int    cnt_hi;
  int    cnt_lo;
  bit    done;
  string cur_req;

  int m_pd, m_pr, m_d, m_r, m_age, m_dl, m_v, m_unl;

  tri_phase_cmp #(.ERR_THR(THR), .DLK_PERIODS(DLK)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_in  (ref_in),
    .div_in  (div_in),
    .dz_code (dz),
    .pump_hi (pump_hi),
    .pump_lo (pump_lo),
    .unlock  (unlock)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, updated at each rising edge, compared 3 ns later
  always @(posedge clk) begin
    int dr, rr, held, vs, nage, nd, nr;
    if (!rst_n) begin
      m_pd = 0; m_pr = 0; m_d = 0; m_r = 0; m_age = 0; m_dl = 0; m_v = 0; m_unl = 0;
    end else begin
      dr = (div_in && !m_pd) ? 1 : 0;
      rr = (ref_in && !m_pr) ? 1 : 0;
      m_pd = div_in; m_pr = ref_in;
      held = (m_d || m_r) ? 1 : 0;
      vs = (held && m_age >= THR) ? 1 : 0;
      if (rr) begin m_unl = (m_v || vs) ? 1 : 0; m_v = 0; end
      else m_v = (m_v || vs) ? 1 : 0;
      nage = held ? ((m_age < THR) ? m_age + 1 : THR) : 0;
      if (held && rr && m_dl == DLK) begin
        m_d = 0; m_r = 0;
      end else begin
        nd = (m_d || dr) ? 1 : 0;
        nr = (m_r || rr) ? 1 : 0;
        if (nd && nr) begin m_d = 0; m_r = 0; end
        else begin m_d = nd; m_r = nr; end
      end
      if (!(m_d || m_r)) m_dl = 0;
      else if (held && rr) m_dl = m_dl + 1;
      m_age = nage;
    end
    #3;
    if (rst_n && !done) begin
      chk(cur_req, "pump_hi vs model", int'(pump_hi), (m_d && m_age >= int'(dz)) ? 1 : 0);
      chk(cur_req, "pump_lo vs model", int'(pump_lo), (m_r && m_age >= int'(dz)) ? 1 : 0);
      chk(cur_req, "unlock vs model", int'(unlock), m_unl);
      cnt_hi += int'(pump_hi);
      cnt_lo += int'(pump_lo);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pair(input bit div_first, input int gap, input int hold);
    cnt_hi = 0; cnt_lo = 0;
    @(negedge clk);
    if (div_first) div_in = 1'b1; else ref_in = 1'b1;
    if (gap > 0) idle(gap);
    div_in = 1'b1; ref_in = 1'b1;
    idle(hold);
    div_in = 1'b0; ref_in = 1'b0;
    idle(4);
  endtask

  initial begin
    int exp_n;
    n_chk = 0; n_fail = 0; done = 0; cur_req = "R1";
    rst_n = 1'b0; ref_in = 1'b0; div_in = 1'b0; dz = 2'd0;
    idle(3);
    chk("R1", "pump_hi in reset", int'(pump_hi), 0);
    chk("R1", "pump_lo in reset", int'(pump_lo), 0);
    chk("R1", "unlock in reset", int'(unlock), 0);
    rst_n = 1'b1;
    idle(5);
    chk("R1", "outputs idle after reset", int'({pump_hi, pump_lo, unlock}), 0);

    cur_req = "R2";
    pair(1'b1, 3, 2);
    chk("R2", "pump_hi cycles div lead 3", cnt_hi, 3);
    chk("R2", "pump_lo cycles div lead 3", cnt_lo, 0);
    cur_req = "R3";
    pair(1'b0, 4, 1);
    chk("R3", "pump_lo cycles ref lead 4", cnt_lo, 4);
    chk("R3", "pump_hi cycles ref lead 4", cnt_hi, 0);
    cur_req = "R4";
    pair(1'b1, 0, 2);
    chk("R4", "enable cycles simultaneous edges", cnt_hi + cnt_lo, 0);
    pair(1'b0, 1, 3);
    chk("R4", "pump_lo cycles ref lead 1", cnt_lo, 1);

    cur_req = "R6";
    dz = 2'd2; pair(1'b1, 2, 1);
    chk("R6", "dz2 gap2 pump_hi", cnt_hi, 0);
    pair(1'b0, 5, 1);
    chk("R6", "dz2 gap5 pump_lo", cnt_lo, 3);
    dz = 2'd3; pair(1'b1, 4, 1);
    chk("R6", "dz3 gap4 pump_hi", cnt_hi, 1);
    dz = 2'd1; pair(1'b0, 1, 1);
    chk("R6", "dz1 gap1 pump_lo", cnt_lo, 0);

    cur_req = "R7";
    dz = 2'd0;
    chk("R7", "unlock after short errors", int'(unlock), 0);
    pair(1'b1, THR, 1);
    chk("R7", "unlock at gap equal threshold", int'(unlock), 0);
    pair(1'b1, THR + 1, 1);
    chk("R7", "unlock at gap above threshold", int'(unlock), 1);
    pair(1'b1, 2, 1);
    chk("R7", "unlock cleared next clean period", int'(unlock), 0);

    cur_req = "R8";
    cnt_lo = 0;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk); ref_in = 1'b1;
      @(negedge clk); ref_in = 1'b0;
      if (i == 3) chk("R8", "pump_lo after third ref edge", int'(pump_lo), 1);
      if (i == 4) chk("R8", "pump_lo forced low at fourth ref edge", int'(pump_lo), 0);
      idle(4);
    end
    chk("R8", "pump_lo stays low after clear", int'(pump_lo), 0);
    idle(4);

    cur_req = "R9";
    cnt_hi = 0;
    @(negedge clk); div_in = 1'b1;
    idle(2);
    ref_in = 1'b1;
    @(negedge clk); ref_in = 1'b0;
    idle(6);
    chk("R9", "pump_hi cycles with div held high", cnt_hi, 2);
    chk("R9", "no retrigger while div held", int'(pump_hi), 0);
    div_in = 1'b0;
    idle(3);

    cur_req = "R2 R3 R4 R6 R7";
    for (int k = 0; k < 300; k++) begin
      bit df;
      int g;
      df = 1'($urandom_range(0, 1));
      g = $urandom_range(0, 9);
      dz = 2'($urandom_range(0, 3));
      pair(df, g, $urandom_range(1, 3));
      exp_n = (g > int'(dz)) ? g - int'(dz) : 0;
      chk("R6", "random interval enable count", df ? cnt_hi : cnt_lo, exp_n);
      chk("R5", "random other enable count", df ? cnt_lo : cnt_hi, 0);
    end

    done = 1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule